// File: doc/BRIEF.md
# Dimension-Order Selecting Route Unit

This unit computes the route for one flit inside a router of a flattened-butterfly network. Each router serves C terminal nodes. It has one network port per other coordinate value in each of N dimensions of radix K. The flit's destination node, traffic class, current virtual channel and arrival port go in. An output port and a permitted virtual-channel window come out in the same cycle, because the unit has no state.

Two dimension orders are supported. X-then-Y corrects the lowest differing coordinate digit first. Y-then-X corrects the highest differing digit first. The order is picked once, on the hop where the flit enters from a terminal port. The choice comes from a random bit, or from comparing the used-credit counts of the two candidate output ports, with the random bit breaking ties. The order is not kept in the flit header. It is encoded by which half of the class's virtual-channel window the flit occupies. Each later hop recovers the order from the current VC. Keeping each order in its own half of the channels removes the cyclic dependency between the two orders.

Top module: `rf_route_unit`

## Requirements
- R1: When dest_node / C equals self_id, out_port is dest_node % C, order_yx is 0, route_err is 0, and the VC window is the class's full range.
- R2: Class code 0 uses VCs 0..3, code 1 uses 4..7, code 2 uses 8..11 and code 3 uses 13..13. Any other code (4..7) uses 0..NUM_VCS-1.
- R3: Router and node coordinates are base-K digits, with digit d of self_id equal to (self_id / K^d) % K. In X-then-Y order the port fixes the lowest differing digit d with target digit t. The port number is C + d*(K-1) + t', where t' = t-1 if t exceeds this router's digit d, else t.
- R4: In Y-then-X order the same port formula is applied to the highest differing digit.
- R5: For a flit arriving on a port numbered below C with adaptive_en = 0, rand_bit = 1 selects X-then-Y and rand_bit = 0 selects Y-then-X.
- R6: For a flit arriving on a port below C with adaptive_en = 1, the unit compares the used-credit counts of the two candidate ports. Port p's count is port_used_credit[p*CRED_W +: CRED_W]. A higher X-then-Y count selects Y-then-X, a lower one selects X-then-Y, and an equal one falls back to rand_bit as in R5.
- R7: For a flit arriving on a port numbered C or above, X-then-Y applies when cur_vc < begin + h, where h = (end - begin + 1) / 2. Otherwise Y-then-X applies. The credits and rand_bit have no effect.
- R8: On a network hop, X-then-Y gives the window begin..end-h and Y-then-X gives begin+h..end. order_yx reports the order, with 1 meaning Y-then-X.
- R9: route_err is 1 on a network hop whose class window holds fewer than two VCs, and also whenever the output port is not below C + N*(K-1). It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| self_id | input | RID_W (4) | Identifier of this router |
| dest_node | input | NODE_W (6) | Destination terminal node index |
| flit_class | input | 3 | Traffic class code |
| cur_vc | input | VC_W (4) | VC the flit currently occupies |
| in_port | input | PORT_W (4) | Port the flit arrived on |
| adaptive_en | input | 1 | 1: pick the order from credits at injection, 0: use rand_bit |
| rand_bit | input | 1 | Random bit supplied from outside |
| port_used_credit | input | RADIX*CRED_W (40) | Used-credit count of every output port |
| out_port | output | PORT_W (4) | Selected output port |
| vc_lo | output | VC_W (4) | Lowest permitted VC |
| vc_hi | output | VC_W (4) | Highest permitted VC |
| order_yx | output | 1 | Dimension order in force (1 = Y-then-X) |
| route_err | output | 1 | Narrow class window or port beyond radix |

## Verification
The checker re-evaluates several things against every input combination the unit sees. It confirms that delivery to a local terminal yields the modulo port. It confirms that a transit hop always leaves on a network port inside the radix. It confirms that the granted window is ordered and lies inside the channel space, and that a transit flit whose VC lies in its class stays inside the window it is given. It also confirms that random-mode injection follows the random bit. Which digit each order corrects and the exact credit comparison at injection depend on the candidate ports, so only the bench's reference model shows them. The same holds for tie-breaking and for the error on a one-channel class, which the bench covers with directed vectors and seeded random ones.

// File: rtl/rf_pkg.sv
package rf_pkg;

    typedef enum logic [2:0] {
        CLS_RD_REQ = 3'd0,
        CLS_WR_REQ = 3'd1,
        CLS_RD_RSP = 3'd2,
        CLS_WR_RSP = 3'd3
    } rf_class_e;

    typedef enum logic {
        ORD_XY = 1'b0,
        ORD_YX = 1'b1
    } rf_order_e;

    // Network port that sets dimension dim to digit tgt; own digit is skipped.
    function automatic int unsigned rf_net_port(
        input int unsigned conc,
        input int unsigned radix_k,
        input int unsigned dim,
        input int unsigned tgt,
        input int unsigned own
    );
        return conc + dim * (radix_k - 1) + ((tgt > own) ? tgt - 1 : tgt);
    endfunction

endpackage

// File: rtl/rf_class_map.sv
module rf_class_map
    import rf_pkg::*;
#(
    parameter int NUM_VCS = 16,
    parameter int RDQ_FIRST = 0,  parameter int RDQ_LAST = 3,
    parameter int WRQ_FIRST = 4,  parameter int WRQ_LAST = 7,
    parameter int RDP_FIRST = 8,  parameter int RDP_LAST = 11,
    parameter int WRP_FIRST = 13, parameter int WRP_LAST = 13,
    localparam int VC_W = $clog2(NUM_VCS)
) (
    input  logic [2:0]      cls,
    output logic [VC_W-1:0] vc_begin,
    output logic [VC_W-1:0] vc_end
);

    always_comb begin
        case (cls)
            CLS_RD_REQ: begin vc_begin = VC_W'(RDQ_FIRST); vc_end = VC_W'(RDQ_LAST); end
            CLS_WR_REQ: begin vc_begin = VC_W'(WRQ_FIRST); vc_end = VC_W'(WRQ_LAST); end
            CLS_RD_RSP: begin vc_begin = VC_W'(RDP_FIRST); vc_end = VC_W'(RDP_LAST); end
            CLS_WR_RSP: begin vc_begin = VC_W'(WRP_FIRST); vc_end = VC_W'(WRP_LAST); end
            default:    begin vc_begin = '0;               vc_end = VC_W'(NUM_VCS - 1); end
        endcase
    end

endmodule

// File: rtl/rf_dim_select.sv
module rf_dim_select
    import rf_pkg::*;
#(
    parameter int C = 4,
    parameter int K = 4,
    parameter int N = 2,
    localparam int ROUTERS = K ** N,
    localparam int RID_W   = $clog2(ROUTERS),
    localparam int RADIX   = C + N * (K - 1),
    localparam int PORT_W  = $clog2(RADIX),
    localparam int DIG_W   = $clog2(K),
    localparam int DIM_W   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [RID_W-1:0]  self_id,
    input  logic [RID_W-1:0]  dest_rtr,
    output logic [PORT_W-1:0] port_xy,
    output logic [PORT_W-1:0] port_yx
);

    logic [DIG_W-1:0] own_dig [N];
    logic [DIG_W-1:0] dst_dig [N];
    logic [N-1:0]     differ;

    for (genvar g = 0; g < N; g++) begin : g_digit
        assign own_dig[g] = DIG_W'((32'(self_id)  / (K ** g)) % K);
        assign dst_dig[g] = DIG_W'((32'(dest_rtr) / (K ** g)) % K);
        assign differ[g]  = (own_dig[g] != dst_dig[g]);
    end

    logic [DIM_W-1:0] low_dim, high_dim;

    always_comb begin
        low_dim  = '0;
        high_dim = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (differ[i]) low_dim = DIM_W'(i);
        end
        for (int i = 0; i < N; i++) begin
            if (differ[i]) high_dim = DIM_W'(i);
        end
    end

    always_comb begin
        port_xy = PORT_W'(rf_net_port(C, K, 32'(low_dim),
                                      32'(dst_dig[low_dim]), 32'(own_dig[low_dim])));
        port_yx = PORT_W'(rf_net_port(C, K, 32'(high_dim),
                                      32'(dst_dig[high_dim]), 32'(own_dig[high_dim])));
    end

endmodule

// File: rtl/rf_order_pick.sv
module rf_order_pick
    import rf_pkg::*;
#(
    parameter int CRED_W = 4,
    parameter int VC_W   = 4
) (
    input  logic              injecting,
    input  logic              adaptive_en,
    input  logic              rand_bit,
    input  logic [CRED_W-1:0] cred_xy,
    input  logic [CRED_W-1:0] cred_yx,
    input  logic [VC_W-1:0]   cur_vc,
    input  logic [VC_W:0]     split_vc,
    output rf_order_e         order
);

    rf_order_e coin;
    assign coin = rand_bit ? ORD_XY : ORD_YX;

    always_comb begin
        if (injecting) begin
            if (!adaptive_en)            order = coin;
            else if (cred_xy > cred_yx)  order = ORD_YX;
            else if (cred_xy < cred_yx)  order = ORD_XY;
            else                         order = coin;
        end else begin
            order = ({1'b0, cur_vc} < split_vc) ? ORD_XY : ORD_YX;
        end
    end

endmodule

// File: rtl/rf_route_unit.sv
module rf_route_unit
    import rf_pkg::*;
#(
    parameter int C       = 4,
    parameter int K       = 4,
    parameter int N       = 2,
    parameter int NUM_VCS = 16,
    parameter int CRED_W  = 4,
    parameter int RDQ_FIRST = 0,  parameter int RDQ_LAST = 3,
    parameter int WRQ_FIRST = 4,  parameter int WRQ_LAST = 7,
    parameter int RDP_FIRST = 8,  parameter int RDP_LAST = 11,
    parameter int WRP_FIRST = 13, parameter int WRP_LAST = 13,
    localparam int ROUTERS = K ** N,
    localparam int NODES   = ROUTERS * C,
    localparam int RID_W   = $clog2(ROUTERS),
    localparam int NODE_W  = $clog2(NODES),
    localparam int RADIX   = C + N * (K - 1),
    localparam int PORT_W  = $clog2(RADIX),
    localparam int VC_W    = $clog2(NUM_VCS)
) (
    input  logic [RID_W-1:0]        self_id,
    input  logic [NODE_W-1:0]       dest_node,
    input  logic [2:0]              flit_class,
    input  logic [VC_W-1:0]         cur_vc,
    input  logic [PORT_W-1:0]       in_port,
    input  logic                    adaptive_en,
    input  logic                    rand_bit,
    input  logic [RADIX*CRED_W-1:0] port_used_credit,
    output logic [PORT_W-1:0]       out_port,
    output logic [VC_W-1:0]         vc_lo,
    output logic [VC_W-1:0]         vc_hi,
    output logic                    order_yx,
    output logic                    route_err
);

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [VC_W-1:0]   lo;
        logic [VC_W-1:0]   hi;
        rf_order_e         order;
        logic              err;
    } route_t;

    // destination router and local terminal port
    logic [RID_W-1:0]  dest_rtr;
    logic [PORT_W-1:0] eject_port;
    logic              at_dest, injecting;

    assign dest_rtr   = RID_W'(32'(dest_node) / C);
    assign eject_port = PORT_W'(32'(dest_node) % C);
    assign at_dest    = (dest_rtr == self_id);
    assign injecting  = (32'(in_port) < C);

    // class window
    logic [VC_W-1:0] vc_begin, vc_end;

    rf_class_map #(
        .NUM_VCS(NUM_VCS),
        .RDQ_FIRST(RDQ_FIRST), .RDQ_LAST(RDQ_LAST),
        .WRQ_FIRST(WRQ_FIRST), .WRQ_LAST(WRQ_LAST),
        .RDP_FIRST(RDP_FIRST), .RDP_LAST(RDP_LAST),
        .WRP_FIRST(WRP_FIRST), .WRP_LAST(WRP_LAST)
    ) u_map (
        .cls     (flit_class),
        .vc_begin(vc_begin),
        .vc_end  (vc_end)
    );

    logic [VC_W:0] win_size, half, split_vc;
    logic          narrow;

    assign win_size = {1'b0, vc_end} - {1'b0, vc_begin} + (VC_W+1)'(1);
    assign half     = win_size >> 1;
    assign split_vc = {1'b0, vc_begin} + half;
    assign narrow   = (win_size < (VC_W+1)'(2));

    // candidate network ports
    logic [PORT_W-1:0] port_xy, port_yx;

    rf_dim_select #(.C(C), .K(K), .N(N)) u_dims (
        .self_id (self_id),
        .dest_rtr(dest_rtr),
        .port_xy (port_xy),
        .port_yx (port_yx)
    );

    // credit lookup for both candidates
    logic [CRED_W-1:0] cred_xy, cred_yx;

    always_comb begin
        cred_xy = '0;
        cred_yx = '0;
        for (int p = 0; p < RADIX; p++) begin
            if (PORT_W'(p) == port_xy) cred_xy = port_used_credit[p*CRED_W +: CRED_W];
            if (PORT_W'(p) == port_yx) cred_yx = port_used_credit[p*CRED_W +: CRED_W];
        end
    end

    rf_order_e order;

    rf_order_pick #(.CRED_W(CRED_W), .VC_W(VC_W)) u_pick (
        .injecting  (injecting),
        .adaptive_en(adaptive_en),
        .rand_bit   (rand_bit),
        .cred_xy    (cred_xy),
        .cred_yx    (cred_yx),
        .cur_vc     (cur_vc),
        .split_vc   (split_vc),
        .order      (order)
    );

    // result assembly
    route_t res;

    always_comb begin
        if (at_dest) begin
            res.port  = eject_port;
            res.lo    = vc_begin;
            res.hi    = vc_end;
            res.order = ORD_XY;
            res.err   = 1'b0;
        end else if (order == ORD_XY) begin
            res.port  = port_xy;
            res.lo    = vc_begin;
            res.hi    = vc_end - half[VC_W-1:0];
            res.order = ORD_XY;
            res.err   = narrow;
        end else begin
            res.port  = port_yx;
            res.lo    = split_vc[VC_W-1:0];
            res.hi    = vc_end;
            res.order = ORD_YX;
            res.err   = narrow;
        end
        if (32'(res.port) >= RADIX) res.err = 1'b1;
    end

    assign out_port  = res.port;
    assign vc_lo     = res.lo;
    assign vc_hi     = res.hi;
    assign order_yx  = (res.order == ORD_YX);
    assign route_err = res.err;

endmodule

// File: rtl/rf_route_chk.sv
module rf_route_chk #(
    parameter int C       = 4,
    parameter int K       = 4,
    parameter int N       = 2,
    parameter int NUM_VCS = 16,
    parameter int RDQ_FIRST = 0,  parameter int RDQ_LAST = 3,
    parameter int WRQ_FIRST = 4,  parameter int WRQ_LAST = 7,
    parameter int RDP_FIRST = 8,  parameter int RDP_LAST = 11,
    parameter int WRP_FIRST = 13, parameter int WRP_LAST = 13,
    localparam int ROUTERS = K ** N,
    localparam int NODES   = ROUTERS * C,
    localparam int RID_W   = $clog2(ROUTERS),
    localparam int NODE_W  = $clog2(NODES),
    localparam int RADIX   = C + N * (K - 1),
    localparam int PORT_W  = $clog2(RADIX),
    localparam int VC_W    = $clog2(NUM_VCS)
) (
    input logic [RID_W-1:0]  self_id,
    input logic [NODE_W-1:0] dest_node,
    input logic [2:0]        flit_class,
    input logic [VC_W-1:0]   cur_vc,
    input logic [PORT_W-1:0] in_port,
    input logic              adaptive_en,
    input logic              rand_bit,
    input logic [PORT_W-1:0] out_port,
    input logic [VC_W-1:0]   vc_lo,
    input logic [VC_W-1:0]   vc_hi,
    input logic              order_yx,
    input logic              route_err
);

    int  cb, ce;
    logic local_dest, from_term;

    always_comb begin
        case (flit_class)
            3'd0:    begin cb = RDQ_FIRST; ce = RDQ_LAST; end
            3'd1:    begin cb = WRQ_FIRST; ce = WRQ_LAST; end
            3'd2:    begin cb = RDP_FIRST; ce = RDP_LAST; end
            3'd3:    begin cb = WRP_FIRST; ce = WRP_LAST; end
            default: begin cb = 0;         ce = NUM_VCS - 1; end
        endcase
        local_dest = ((32'(dest_node) / C) == 32'(self_id));
        from_term  = (32'(in_port) < C);
    end

    always_comb begin
        // R1
        eject_port_chk: assert (!local_dest ||
            (32'(out_port) == 32'(dest_node) % C && !order_yx && !route_err));
        // R3
        net_port_chk: assert (local_dest ||
            (32'(out_port) >= C && 32'(out_port) < RADIX));
        // R8
        window_order_chk: assert (route_err || (vc_lo <= vc_hi && 32'(vc_hi) < NUM_VCS));
        // R5
        coin_order_chk: assert (local_dest || !from_term || adaptive_en ||
            (order_yx == !rand_bit));
        // R7
        stay_in_half_chk: assert (local_dest || from_term || route_err ||
            32'(cur_vc) < cb || 32'(cur_vc) > ce ||
            (cur_vc >= vc_lo && cur_vc <= vc_hi));
    end

endmodule

bind rf_route_unit rf_route_chk #(
    .C(C), .K(K), .N(N), .NUM_VCS(NUM_VCS),
    .RDQ_FIRST(RDQ_FIRST), .RDQ_LAST(RDQ_LAST),
    .WRQ_FIRST(WRQ_FIRST), .WRQ_LAST(WRQ_LAST),
    .RDP_FIRST(RDP_FIRST), .RDP_LAST(RDP_LAST),
    .WRP_FIRST(WRP_FIRST), .WRP_LAST(WRP_LAST)
) u_chk (
    .self_id    (self_id),
    .dest_node  (dest_node),
    .flit_class (flit_class),
    .cur_vc     (cur_vc),
    .in_port    (in_port),
    .adaptive_en(adaptive_en),
    .rand_bit   (rand_bit),
    .out_port   (out_port),
    .vc_lo      (vc_lo),
    .vc_hi      (vc_hi),
    .order_yx   (order_yx),
    .route_err  (route_err)
);

// File: tb/sim_rf_route_unit.sv
`timescale 1ns/1ps
module sim_rf_route_unit;

    localparam int C = 4, K = 4, N = 2, NUM_VCS = 16, CRED_W = 4;
    localparam int RADIX = C + N * (K - 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [3:0]            self_id;
    logic [5:0]            dest_node;
    logic [2:0]            flit_class;
    logic [3:0]            cur_vc;
    logic [3:0]            in_port;
    logic                  adaptive_en, rand_bit;
    logic [RADIX*CRED_W-1:0] port_used_credit;
    logic [3:0]            out_port, vc_lo, vc_hi;
    logic                  order_yx, route_err;

    int cred [RADIX];
    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    rf_route_unit u0 (
        .self_id(self_id), .dest_node(dest_node), .flit_class(flit_class),
        .cur_vc(cur_vc), .in_port(in_port), .adaptive_en(adaptive_en),
        .rand_bit(rand_bit), .port_used_credit(port_used_credit),
        .out_port(out_port), .vc_lo(vc_lo), .vc_hi(vc_hi),
        .order_yx(order_yx), .route_err(route_err)
    );

    function automatic int digit(int v, int d);
        int q = v;
        for (int i = 0; i < d; i++) q = q / K;
        return q % K;
    endfunction

    function automatic int nport(int d, int t, int o);
        return C + d * (K - 1) + ((t > o) ? t - 1 : t);
    endfunction

    // reference model from the requirements
    task automatic model(output int e_port, output int e_lo, output int e_hi,
                         output int e_yx, output int e_err, output string tag);
        int b, e, dr, lowd, highd, pxy, pyx, h;
        case (flit_class)
            3'd0: begin b = 0;  e = 3;  end
            3'd1: begin b = 4;  e = 7;  end
            3'd2: begin b = 8;  e = 11; end
            3'd3: begin b = 13; e = 13; end
            default: begin b = 0; e = NUM_VCS - 1; end
        endcase
        dr = int'(dest_node) / C;
        if (dr == int'(self_id)) begin
            e_port = int'(dest_node) % C; e_lo = b; e_hi = e; e_yx = 0; e_err = 0;
            tag = "R1";
            return;
        end
        lowd = -1; highd = -1;
        for (int d = 0; d < N; d++)
            if (digit(dr, d) != digit(int'(self_id), d)) begin
                if (lowd < 0) lowd = d;
                highd = d;
            end
        pxy = nport(lowd, digit(dr, lowd), digit(int'(self_id), lowd));
        pyx = nport(highd, digit(dr, highd), digit(int'(self_id), highd));
        h = (e - b + 1) / 2;
        if (int'(in_port) < C) begin
            if (adaptive_en) begin
                tag = "R6";
                if (cred[pxy] > cred[pyx])      e_yx = 1;
                else if (cred[pxy] < cred[pyx]) e_yx = 0;
                else                            e_yx = rand_bit ? 0 : 1;
            end else begin
                tag = "R5";
                e_yx = rand_bit ? 0 : 1;
            end
        end else begin
            tag = "R7";
            e_yx = (int'(cur_vc) < b + h) ? 0 : 1;
        end
        e_port = e_yx ? pyx : pxy;
        e_lo   = e_yx ? b + h : b;
        e_hi   = e_yx ? e : e - h;
        e_err  = ((e - b + 1) < 2) ? 1 : 0;
    endtask

    task automatic check(string what, string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (self=%0d dest=%0d cls=%0d vc=%0d in=%0d)",
                     req, what, act, exp, self_id, dest_node, flit_class, cur_vc, in_port);
        end
    endtask

    task automatic apply(int s, int dn, int cl, int vc, int ip, bit ad, bit rb);
        @(posedge clk);
        self_id = 4'(s); dest_node = 6'(dn); flit_class = 3'(cl);
        cur_vc = 4'(vc); in_port = 4'(ip); adaptive_en = ad; rand_bit = rb;
        for (int p = 0; p < RADIX; p++) port_used_credit[p*CRED_W +: CRED_W] = CRED_W'(cred[p]);
        @(negedge clk);
    endtask

    task automatic verify();
        int ep, el, eh, ey, ee;
        string tg;
        model(ep, el, eh, ey, ee, tg);
        check("port", (tg == "R1") ? "R1" : (ey ? "R4" : "R3"), int'(out_port), ep);
        check("order", tg, int'(order_yx), ey);
        check("vc_lo", (tg == "R1") ? "R2" : "R8", int'(vc_lo), el);
        check("vc_hi", (tg == "R1") ? "R2" : "R8", int'(vc_hi), eh);
        check("err", "R9", int'(route_err), ee);
    endtask

    initial begin
        #(20ns * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int p = 0; p < RADIX; p++) cred[p] = 0;

        // all-zero inputs: router 0 delivers node 0 on port 0 (R1)
        apply(0, 0, 0, 0, 0, 0, 0);
        check("port", "R1", int'(out_port), 0);
        verify();

        // R1 R2: local delivery, node 22 on router 5, port 2, window 0..3
        apply(5, 22, 0, 1, 6, 0, 0);
        check("port", "R1", int'(out_port), 2);
        check("vc_hi", "R2", int'(vc_hi), 3);
        verify();

        // R3: router 0 to router 6 (digits 2,1), write request vc 4 -> X-then-Y, port 5
        apply(0, 24, 1, 4, 5, 0, 0);
        check("port", "R3", int'(out_port), 5);
        check("vc_hi", "R8", int'(vc_hi), 5);
        verify();

        // R4 R7: same flit in upper half vc 6 -> Y-then-X, port 7, window 6..7
        apply(0, 24, 1, 6, 5, 1, 1);
        check("port", "R4", int'(out_port), 7);
        check("vc_lo", "R8", int'(vc_lo), 6);
        verify();

        // R6: injection, XY candidate (5) busier than YX (7)
        cred[5] = 9; cred[7] = 3;
        apply(0, 24, 2, 0, 1, 1, 1);
        check("order", "R6", int'(order_yx), 1);
        verify();
        // R6: tie broken by rand_bit = 1 -> X-then-Y
        cred[7] = 9;
        apply(0, 24, 2, 0, 1, 1, 1);
        check("order", "R6", int'(order_yx), 0);
        verify();

        // R5: random mode, rand_bit 0 -> Y-then-X regardless of credits
        apply(0, 24, 2, 0, 3, 0, 0);
        check("order", "R5", int'(order_yx), 1);
        verify();

        // R9: one-VC class on a network hop flags an error
        apply(3, 60, 3, 13, 8, 0, 1);
        check("err", "R9", int'(route_err), 1);
        verify();

        // R2: unassigned class code 6 spreads over all VCs, X-then-Y lower half 0..7
        apply(3, 60, 6, 2, 8, 0, 1);
        check("vc_hi", "R2", int'(vc_hi), 7);
        verify();

        // seeded random mix
        for (int i = 0; i < 3000; i++) begin
            for (int p = 0; p < RADIX; p++) cred[p] = int'($urandom_range(0, 15));
            apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 63)),
                  int'($urandom_range(0, 7)), int'($urandom_range(0, 15)),
                  int'($urandom_range(0, RADIX - 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)));
            verify();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule